// File: doc/BRIEF.md
# Keyed-feed watchdog timer

This block is a memory-mapped watchdog. Software sets it up through four 32-bit registers on a plain single-cycle register bus: a control/status word, a reload limit, a feed port and a live count. Once started, a down-counter steps once every four clocks. If software does not feed the watchdog in time, the block flags a timeout. It then raises a level interrupt and, if selected, a fixed-length system reset pulse.

Software feeds the watchdog with two keyed writes to the feed port, 0xAA and then 0x55. A valid feed reloads the counter from the limit register. The first valid feed after the watchdog is enabled also starts the counter. A wrong key to the feed port is treated as a timeout at once. Software cannot clear the enable bit. Only the block's reset input stops the watchdog.

Reads are combinational: `bus_rdata_o` reflects `bus_addr_i` in the same cycle. Writes take effect at the next rising clock edge. The bus has no wait states and no back-pressure. All pins are plain control and status signals.

Top module: `kwdt_top`

## Requirements
- R1: Register map on byte offsets. 0x0 is control/status. 0x4 is the reload limit. 0x8 is the feed port, which reads as zero. 0xC is the live count, which is read-only; writes to it are ignored.
- R2: A limit write below 0xFF stores 0xFF. Any other value is stored as written.
- R3: Writing 1 to control bit 0 enables the watchdog. A later write of 0 to that bit leaves it set.
- R4: The counter starts on the first valid feed after enable: a write of 0x000000AA to 0x8 followed by a write of 0x00000055 as the next feed write. Until that feed, 0xC reads as the limit value. A valid feed loads the count with the limit.
- R5: A running counter decrements once every 4 clocks. A timeout occurs (limit+1)×4 clocks after a feed. The counter then reloads from the limit and keeps running.
- R6: While enabled, any feed write that is not the expected next key causes a timeout at the next clock edge. While disabled, feed writes have no effect.
- R7: A write to any other register between the two keys aborts the sequence. The next feed write must then be 0xAA, or it counts as a wrong key.
- R8: Control bit 2 is set by every timeout. Writing 0 to it clears it; writing 1 has no effect. A timeout in the same cycle as a clearing write wins.
- R9: Control bit 3 is set by every timeout and cannot be cleared by software. `irq_o` is high whenever bit 3 is set.
- R10: If control bit 1 is 1 at the moment of a timeout, `sys_rst_o` is high for exactly 4 cycles, starting with the cycle after the timeout. If bit 1 is 0, there is no pulse.
- R11: `rst_ni` low clears enable, bit 1, both flags, the counter and the feed sequence. It also sets the limit to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| bus_addr_i | input | 4 | Register byte address |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Level interrupt, follows control bit 3 |
| sys_rst_o | output | 1 | Registered system reset pulse |

## Verification
The assertions check on every cycle the invariants that hold in any state:
- the enable bit and the interrupt flag never fall;
- a timeout always lands in both flags and, when reset is selected, starts the reset pulse;
- a write elsewhere returns the feed sequence to idle;
- the count stays still between prescaler ticks;
- a disabled watchdog never times out.

Only the bench's scenarios can show the exact expiry distance of (limit+1)×4 clocks, the pulse length, and the abort and wrong-key cases. They also cover that feeds are ignored before enable and what a reset in mid-run restores. A behavioural model compares the read data and both outputs against the design on every clock.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // register byte offsets (software decodes these)
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_LIMIT = 8'h04;
  localparam logic [7:0] OFF_KICK  = 8'h08;
  localparam logic [7:0] OFF_COUNT = 8'h0C;

  // control/status bit positions
  localparam int CB_ENABLE = 0;
  localparam int CB_RSTSEL = 1;
  localparam int CB_TOF    = 2;
  localparam int CB_IRQ    = 3;

  // feed keys, in the order they must arrive
  localparam logic [31:0] KEY_FIRST  = 32'h0000_00AA;
  localparam logic [31:0] KEY_SECOND = 32'h0000_0055;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/kwdt_feed.sv
module kwdt_feed
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              enabled_i,
  output logic              feed_ok_o,
  output logic              feed_bad_o
);
  key_state_e st_q, st_d;
  logic kick_wr, other_wr, is_first, is_second;

  assign kick_wr   = wr_en_i && (addr_i == ADDR_W'(OFF_KICK)) && enabled_i;
  assign other_wr  = wr_en_i && (addr_i != ADDR_W'(OFF_KICK));
  assign is_first  = (wdata_i == DATA_W'(KEY_FIRST));
  assign is_second = (wdata_i == DATA_W'(KEY_SECOND));

  always_comb begin
    st_d       = st_q;
    feed_ok_o  = 1'b0;
    feed_bad_o = 1'b0;
    if (other_wr) begin
      st_d = KEY_IDLE;
    end else if (kick_wr) begin
      case (st_q)
        KEY_IDLE: begin
          if (is_first) st_d = KEY_ARMED;
          else          feed_bad_o = 1'b1;
        end
        default: begin
          st_d = KEY_IDLE;
          if (is_second) feed_ok_o  = 1'b1;
          else           feed_bad_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

  // R7: a write to another register leaves the sequence idle
  p_abort_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_wr |=> (st_q == KEY_IDLE));

  // R4: a completed feed always leaves the sequence idle
  p_ok_returns_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_ok_o |=> (st_q == KEY_IDLE));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             start_i,
  input  logic             force_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick     = (pre_q == PRE_W'(PRESCALE - 1));
  assign expire_o = run_q && tick && (cnt_q == '0) && !start_i;
  assign count_o  = run_q ? cnt_q : limit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= limit_i;
      pre_q <= '0;
    end else if (run_q && (expire_o || force_i)) begin
      cnt_q <= limit_i;
      pre_q <= '0;
    end else if (run_q) begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R4: a valid feed starts the counter loaded with the limit
  p_start_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && (cnt_q == $past(limit_i))));

  // R5: between prescaler ticks the count stays still
  p_hold_between_ticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && !force_i && !tick) |=> $stable(cnt_q));

  // R5: once running, only reset stops it
  p_run_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o
);
  localparam int PW = $clog2(HOLD_CYCLES + 1);

  logic [PW-1:0] cnt_q;
  logic          pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (fire_i)             cnt_q <= PW'(HOLD_CYCLES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - PW'(1);
      pulse_q <= fire_i || (cnt_q > PW'(1));
    end
  end

  assign rst_o = pulse_q;

  // R10: a selected timeout drives the reset output on the next cycle
  p_fire_starts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rst_o);

  // R10: the output never rises without a trigger
  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_o && !fire_i) |=> !rst_o);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int LIMIT_MIN   = 255,
  parameter int PRESCALE    = 4,
  parameter int RST_HOLD    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam logic [CNT_W-1:0] LIM_FLOOR = CNT_W'(LIMIT_MIN);

  logic             en_q, sel_q, tof_q, int_q;
  logic [CNT_W-1:0] limit_q, limit_in, count;
  logic             ctrl_wr, limit_wr;
  logic             feed_ok, feed_bad, expire, tmo_event;

  assign ctrl_wr   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign limit_wr  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_LIMIT));
  assign limit_in  = bus_wdata_i[CNT_W-1:0];
  assign tmo_event = expire || feed_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sel_q   <= 1'b0;
      tof_q   <= 1'b0;
      int_q   <= 1'b0;
      limit_q <= LIM_FLOOR;
    end else begin
      if (ctrl_wr) begin
        en_q  <= en_q | bus_wdata_i[CB_ENABLE];
        sel_q <= bus_wdata_i[CB_RSTSEL];
      end
      if (tmo_event)                              tof_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata_i[CB_TOF])   tof_q <= 1'b0;
      if (tmo_event) int_q <= 1'b1;
      if (limit_wr)  limit_q <= (limit_in < LIM_FLOOR) ? LIM_FLOOR : limit_in;
    end
  end

  kwdt_feed #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_feed (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .enabled_i  (en_q),
    .feed_ok_o  (feed_ok),
    .feed_bad_o (feed_bad)
  );

  kwdt_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .limit_i  (limit_q),
    .start_i  (feed_ok),
    .force_i  (feed_bad),
    .expire_o (expire),
    .count_o  (count)
  );

  kwdt_pulse #(.HOLD_CYCLES(RST_HOLD)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (tmo_event && sel_q),
    .rst_o  (sys_rst_o)
  );

  assign irq_o = int_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFF_CTRL)) begin
      bus_rdata_o[CB_ENABLE] = en_q;
      bus_rdata_o[CB_RSTSEL] = sel_q;
      bus_rdata_o[CB_TOF]    = tof_q;
      bus_rdata_o[CB_IRQ]    = int_q;
    end else if (bus_addr_i == ADDR_W'(OFF_LIMIT)) begin
      bus_rdata_o[CNT_W-1:0] = limit_q;
    end else if (bus_addr_i == ADDR_W'(OFF_COUNT)) begin
      bus_rdata_o[CNT_W-1:0] = count;
    end
  end

  // R3: enable never falls while out of reset
  p_enable_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);

  // R9: the interrupt flag cannot be cleared by software
  p_irq_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q |=> int_q);

  // R8: any timeout lands in both flags
  p_event_sets_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_event |=> (tof_q && int_q));

  // R2: a limit write never leaves a value below the floor
  p_limit_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_wr |=> (limit_q >= LIM_FLOOR));

  // R6: a disabled watchdog never times out
  p_disabled_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !tmo_event);
endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [3:0]  bus_addr_i;
  logic        bus_we_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic        sys_rst_o;

  kwdt_top dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .sys_rst_o   (sys_rst_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  // behavioural reference state
  bit          m_en, m_sel, m_tof, m_int, m_run, m_key;
  longint      m_lim, m_cnt;
  int          m_pre, m_pulse;
  bit          t_kick, t_good, t_bad, t_exp, t_ev, t_sel_old;
  longint      t_lim_old;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_sel = 0; m_tof = 0; m_int = 0; m_run = 0; m_key = 0;
      m_lim = 255; m_cnt = 0; m_pre = 0; m_pulse = 0;
    end else begin
      t_lim_old = m_lim;
      t_sel_old = m_sel;
      t_kick = bus_we_i && bus_addr_i == 4'h8 && m_en;
      t_good = t_kick && m_key && bus_wdata_i == 32'h55;
      t_bad  = t_kick && !(m_key ? bus_wdata_i == 32'h55 : bus_wdata_i == 32'hAA);
      t_exp  = m_run && m_pre == 3 && m_cnt == 0 && !t_good;
      t_ev   = t_exp || t_bad;
      if (bus_we_i && bus_addr_i != 4'h8) m_key = 0;
      else if (t_kick) m_key = !m_key && bus_wdata_i == 32'hAA;
      if (bus_we_i && bus_addr_i == 4'h4)
        m_lim = (bus_wdata_i < 255) ? 255 : longint'(bus_wdata_i);
      if (bus_we_i && bus_addr_i == 4'h0) begin
        m_en  = m_en | bus_wdata_i[0];
        m_sel = bus_wdata_i[1];
        if (!bus_wdata_i[2]) m_tof = 0;
      end
      if (t_ev) begin m_tof = 1; m_int = 1; end
      if (t_good) begin
        m_run = 1; m_cnt = t_lim_old; m_pre = 0;
      end else if (t_ev && m_run) begin
        m_cnt = t_lim_old; m_pre = 0;
      end else if (m_run) begin
        if (m_pre == 3) begin m_pre = 0; m_cnt = m_cnt - 1; end
        else m_pre = m_pre + 1;
      end
      if (t_ev && t_sel_old) m_pulse = 4;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
    end
  end

  function automatic logic [31:0] model_rd(logic [3:0] a);
    case (a)
      4'h0: return {28'd0, m_int, m_tof, m_sel, m_en};
      4'h4: return 32'(m_lim);
      4'hC: return 32'(m_run ? m_cnt : m_lim);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk_i) begin
    #1;
    if (!done) begin
      check("R9 irq_o", {31'd0, irq_o}, {31'd0, m_int});
      check("R10 sys_rst_o", {31'd0, sys_rst_o}, {31'd0, (m_pulse > 0)});
      check(bus_addr_i == 4'hC ? "R5 count read" :
            bus_addr_i == 4'h4 ? "R2 limit read" : "R1 register read",
            bus_rdata_o, model_rd(bus_addr_i));
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got cycle %0d expected end before 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_we_i = 1'b1; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_wdata_i = 32'd0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_we_i = 1'b0;
    #2 d = bus_rdata_o;
  endtask

  initial begin
    logic [31:0] rd;
    int n, hi;
    rst_ni = 1'b0; bus_addr_i = 4'h0; bus_we_i = 1'b0; bus_wdata_i = 32'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    peek(4'h0, rd); check("R11 ctrl after reset", rd, 32'h0);
    peek(4'h4, rd); check("R11 limit after reset", rd, 32'hFF);
    check("R11 outputs after reset", {30'd0, irq_o, sys_rst_o}, 32'h0);

    bus_wr(4'h4, 32'h10);  peek(4'h4, rd); check("R2 limit floor", rd, 32'hFF);
    bus_wr(4'h4, 32'h100); peek(4'h4, rd); check("R2 limit stored", rd, 32'h100);

    bus_wr(4'h8, 32'h12); bus_wr(4'h8, 32'hAA); bus_wr(4'h8, 32'h55);
    peek(4'h0, rd); check("R6 feeds ignored while disabled", rd, 32'h0);
    peek(4'hC, rd); check("R4 count holds limit before start", rd, 32'h100);

    bus_wr(4'h0, 32'h3); bus_wr(4'h0, 32'h2);
    peek(4'h0, rd); check("R3 enable sticky", rd, 32'h3);

    bus_wr(4'hC, 32'h5); peek(4'hC, rd); check("R1 count write ignored", rd, 32'h100);
    peek(4'h8, rd); check("R1 feed reads zero", rd, 32'h0);

    // valid feed, then measure distance to expiry
    bus_wr(4'h8, 32'hAA); bus_wr(4'h8, 32'h55);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk_i); #1; n++;
      if (irq_o) break;
    end
    check("R5 expiry distance", n, (32'h100 + 1) * 4);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (sys_rst_o) hi++;
      @(posedge clk_i); #1;
    end
    check("R10 pulse length", hi, 4);
    peek(4'h0, rd); check("R8 flags after expiry", rd, 32'hF);

    bus_wr(4'h0, 32'h3);
    peek(4'h0, rd); check("R8 flag cleared, R9 flag kept", rd, 32'hB);
    check("R9 irq level", {31'd0, irq_o}, 32'd1);

    bus_wr(4'h0, 32'h1); bus_wr(4'h8, 32'h12);
    peek(4'h0, rd); check("R6 wrong key timeout", rd, 32'hD);
    repeat (3) @(negedge clk_i);
    check("R10 no pulse when unselected", {31'd0, sys_rst_o}, 32'd0);

    bus_wr(4'h0, 32'h5);
    peek(4'h0, rd); check("R8 write 1 no effect", rd, 32'hD);
    bus_wr(4'h0, 32'h1);
    peek(4'h0, rd); check("R8 clear", rd, 32'h9);

    bus_wr(4'h8, 32'hAA); bus_wr(4'h4, 32'h100); bus_wr(4'h8, 32'h55);
    peek(4'h0, rd); check("R7 aborted sequence", rd, 32'hD);

    bus_wr(4'h0, 32'h1);
    bus_wr(4'h8, 32'hAA); bus_wr(4'h8, 32'h55);
    peek(4'h0, rd); check("R4 valid feed no timeout", rd, 32'h9);
    repeat (20) @(negedge clk_i);

    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i); rst_ni = 1'b1;
    peek(4'h0, rd); check("R11 ctrl after mid-run reset", rd, 32'h0);
    peek(4'h4, rd); check("R11 limit after mid-run reset", rd, 32'hFF);
    check("R11 irq after mid-run reset", {31'd0, irq_o}, 32'd0);

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule